// File: doc/BRIEF.md
# Multi-Channel Window and Differential Comparator Matrix

This block turns digitised readings from several DC bus sensing channels into per-channel and per-pair diagnostic flags. The readings may be residual current, segment voltage to earth or an injection response. All channels arrive together as one parallel word on a sample strobe. Each channel feeds two paths:

- A slow path keeps a 16-sample boxcar average and checks it against an upper and lower window, so that gradual leakage shows up.
- A fast path checks the raw sample against a wider window, so that a hard fault is flagged on the strobe where it appears.

Differential checks compare the averaged values of programmable channel pairs, for example a far-node current against a near-ground reference. They raise a flag when the absolute difference exceeds a per-pair limit.

During pre-charge, contactor switching or converter start/stop, the matrix keeps sampling but holds every output flag inactive. Blanking lasts while any transient input is active, and then for a programmed number of further strobes. A stable-mode input ends it early. The first unblanked strobe restarts each average from that sample. All thresholds, pair selections and the blanking length are written at run time through a simple write-only register port.

Top module: `bus_fault_cmp_matrix`

## Requirements
- R1: For each channel, `slow_hi` is set when the averaged value is strictly greater than the channel's slow upper threshold (signed, address ch). `slow_lo` is set when the averaged value is strictly less than the slow lower threshold (address 8+ch). Neither is set inside the window, and `slow_hi` wins if both would hold.
- R2: The averaged value is the sum of the channel's last 16 accepted samples, shifted right arithmetically by 4 (floor division).
- R3: `fast_trip` for a channel is set when the raw sample of that strobe is strictly above the fast upper threshold (address 16+ch) or strictly below the fast lower threshold (address 24+ch).
- R4: `diff_flag[p]` is set when |avg[A] - avg[B]| is strictly greater than the unsigned limit at address 40+p. A is held in bits [2:0] at address 32+p, and B in bits [2:0] at address 36+p.
- R5: Flags are registered and change only on the cycle after an accepted strobe, or when blanking clears them. With no strobe and no blanking they hold.
- R6: While any bit of `trans_act` is high, all flags read zero from the next cycle on, and strobes are still accepted.
- R7: After `trans_act` returns to zero, the next N strobes stay blanked, where N is the 16-bit value at address 44. A new transient reloads N.
- R8: A `stable_mode` pulse while `trans_act` is zero ends the remaining blanking at once.
- R9: The first unblanked strobe after reset or after blanking fills the channel's whole average history with that sample.
- R10: Threshold and pair writes take effect from the next strobe, and they do not disturb the running averages.
- R11: After reset, all flags are zero. The slow and fast windows span the full signed range, every pair limit is 65535, the pairs select channel 0 against 0, and N is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; all channels accepted this cycle |
| smp_data | input | NCH*DW | Signed samples, channel c at bits [c*DW +: DW] |
| trans_act | input | NTRANS | Transient phases active (pre-charge, contactor, converter) |
| stable_mode | input | 1 | Stable operation reported; ends remaining blanking |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| slow_hi | output | NCH | Averaged value above slow window |
| slow_lo | output | NCH | Averaged value below slow window |
| fast_trip | output | NCH | Raw sample outside fast window |
| diff_flag | output | NPAIR | Pair difference above limit |

## Verification
The main function is driven with a deterministic sweep that mixes in-window values with periodic large spikes on a rotating channel. This separates the fast path, which trips on the single spike, from the slow path, whose average moves only by a sixteenth of it. Constant inputs placed exactly on a threshold, and then one count past it, show strict comparison and floor rounding of negative averages. Blanking sequences with different transient bits, a retrigger partway through the count, a stable-mode cut-off and a zero-length setting each produce a distinct number of suppressed strobes. The refill that follows each sequence is visible as an immediate jump of the average. Thresholds are rewritten in the middle of a run to show that new limits apply while the history is kept.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    typedef enum logic [1:0] {
        LVL_IN = 2'd0,
        LVL_HI = 2'd1,
        LVL_LO = 2'd2
    } lvl_e;

    // Window classification with strict bounds; upper side has priority.
    function automatic lvl_e classify(input int v, input int hi, input int lo);
        if (v > hi) return LVL_HI;
        if (v < lo) return LVL_LO;
        return LVL_IN;
    endfunction

endpackage

// File: rtl/cmx_cfg.sv
module cmx_cfg #(
    parameter int NCH   = 8,
    parameter int NPAIR = 4,
    parameter int DW    = 16,
    parameter int BW    = 16,
    parameter int AW    = 8,
    parameter int IW    = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [NCH-1:0][DW-1:0]      th_shi,
    output logic [NCH-1:0][DW-1:0]      th_slo,
    output logic [NCH-1:0][DW-1:0]      th_fhi,
    output logic [NCH-1:0][DW-1:0]      th_flo,
    output logic [NPAIR-1:0][IW-1:0]    sel_a,
    output logic [NPAIR-1:0][IW-1:0]    sel_b,
    output logic [NPAIR-1:0][DW-1:0]    lim,
    output logic [BW-1:0]               blen
);
    localparam int A_SHI  = 0;
    localparam int A_SLO  = NCH;
    localparam int A_FHI  = 2 * NCH;
    localparam int A_FLO  = 3 * NCH;
    localparam int A_SELA = 4 * NCH;
    localparam int A_SELB = 4 * NCH + NPAIR;
    localparam int A_LIM  = 4 * NCH + 2 * NPAIR;
    localparam int A_BLEN = 4 * NCH + 3 * NPAIR;

    localparam logic [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NCH-1:0][DW-1:0]   shi;
        logic [NCH-1:0][DW-1:0]   slo;
        logic [NCH-1:0][DW-1:0]   fhi;
        logic [NCH-1:0][DW-1:0]   flo;
        logic [NPAIR-1:0][IW-1:0] sa;
        logic [NPAIR-1:0][IW-1:0] sb;
        logic [NPAIR-1:0][DW-1:0] lim;
        logic [BW-1:0]            blen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == AW'(A_SHI + i)) cfg_d.shi[i] = wdata;
                if (addr == AW'(A_SLO + i)) cfg_d.slo[i] = wdata;
                if (addr == AW'(A_FHI + i)) cfg_d.fhi[i] = wdata;
                if (addr == AW'(A_FLO + i)) cfg_d.flo[i] = wdata;
            end
            for (int p = 0; p < NPAIR; p++) begin
                if (addr == AW'(A_SELA + p)) cfg_d.sa[p]  = wdata[IW-1:0];
                if (addr == AW'(A_SELB + p)) cfg_d.sb[p]  = wdata[IW-1:0];
                if (addr == AW'(A_LIM + p))  cfg_d.lim[p] = wdata;
            end
            if (addr == AW'(A_BLEN)) cfg_d.blen = wdata[BW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.shi  <= {NCH{S_MAX}};
            cfg_q.slo  <= {NCH{S_MIN}};
            cfg_q.fhi  <= {NCH{S_MAX}};
            cfg_q.flo  <= {NCH{S_MIN}};
            cfg_q.sa   <= '0;
            cfg_q.sb   <= '0;
            cfg_q.lim  <= '1;
            cfg_q.blen <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign th_shi = cfg_q.shi;
    assign th_slo = cfg_q.slo;
    assign th_fhi = cfg_q.fhi;
    assign th_flo = cfg_q.flo;
    assign sel_a  = cfg_q.sa;
    assign sel_b  = cfg_q.sb;
    assign lim    = cfg_q.lim;
    assign blen   = cfg_q.blen;

endmodule

// File: rtl/cmx_blank.sv
module cmx_blank #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          trans_any,
    input  logic          stable_mode,
    input  logic [BW-1:0] blen,
    output logic          blank
);
    typedef struct packed {
        logic [BW-1:0] cnt;
    } bl_t;

    bl_t bl_d, bl_q;

    always_comb begin
        bl_d = bl_q;
        if (trans_any) begin
            bl_d.cnt = blen;
        end else if (stable_mode) begin
            bl_d.cnt = '0;
        end else if (strobe && (bl_q.cnt != '0)) begin
            bl_d.cnt = bl_q.cnt - BW'(1);
        end
        blank = trans_any || (bl_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trans_any |=> (bl_q.cnt == $past(blen)));

    p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trans_any && !stable_mode && strobe && (bl_q.cnt != '0))
        |=> (bl_q.cnt == $past(bl_q.cnt) - BW'(1)));

    p_stable_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trans_any && stable_mode) |=> (bl_q.cnt == '0) && !blank || trans_any);

endmodule

// File: rtl/cmx_boxcar.sv
module cmx_boxcar #(
    parameter int DW = 16,
    parameter int L  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 fill,
    input  logic signed [DW-1:0] s,
    output logic signed [DW-1:0] avg_o
);
    localparam int D  = 1 << L;
    localparam int SW = DW + L;

    typedef struct packed {
        logic [D-1:0][DW-1:0] hist;
        logic [SW-1:0]        sum;
    } bx_t;

    bx_t bx_d, bx_q;
    logic signed [SW-1:0] s_ext, old_ext, sum_nx, sum_sh;

    always_comb begin
        s_ext   = {{L{s[DW-1]}}, s};
        old_ext = {{L{bx_q.hist[D-1][DW-1]}}, bx_q.hist[D-1]};
        sum_nx  = $signed(bx_q.sum) - old_ext + s_ext;
        sum_sh  = sum_nx >>> L;
        bx_d    = bx_q;
        if (en) begin
            if (fill) begin
                for (int k = 0; k < D; k++) bx_d.hist[k] = s;
                bx_d.sum = s_ext <<< L;
            end else begin
                bx_d.hist = {bx_q.hist[D-2:0], s};
                bx_d.sum  = sum_nx;
            end
        end
        avg_o = fill ? s : sum_sh[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bx_q <= '0;
        else        bx_q <= bx_d;
    end

    p_fill_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fill) |=> (bx_q.sum == {$past(s), {L{1'b0}}}));

endmodule

// File: rtl/bus_fault_cmp_matrix.sv
module bus_fault_cmp_matrix #(
    parameter int NCH      = 8,
    parameter int NPAIR    = 4,
    parameter int DW       = 16,
    parameter int AVG_LOG2 = 4,
    parameter int BW       = 16,
    parameter int AW       = 8,
    parameter int NTRANS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [NCH*DW-1:0]   smp_data,
    input  logic [NTRANS-1:0]   trans_act,
    input  logic                stable_mode,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [NCH-1:0]      slow_hi,
    output logic [NCH-1:0]      slow_lo,
    output logic [NCH-1:0]      fast_trip,
    output logic [NPAIR-1:0]    diff_flag
);
    import cmx_pkg::*;

    localparam int IW = $clog2(NCH);

    logic [NCH-1:0][DW-1:0]   th_shi, th_slo, th_fhi, th_flo;
    logic [NPAIR-1:0][IW-1:0] sel_a, sel_b;
    logic [NPAIR-1:0][DW-1:0] lim;
    logic [BW-1:0]            blen;
    logic                     blank;
    logic signed [DW-1:0]     raw_w [NCH];
    logic signed [DW-1:0]     avg_w [NCH];

    typedef struct packed {
        logic             refill;
        logic [NCH-1:0]   shi;
        logic [NCH-1:0]   slo;
        logic [NCH-1:0]   ftr;
        logic [NPAIR-1:0] dfl;
    } mt_t;

    mt_t mt_d, mt_q;

    cmx_cfg #(
        .NCH(NCH), .NPAIR(NPAIR), .DW(DW), .BW(BW), .AW(AW), .IW(IW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .th_shi(th_shi), .th_slo(th_slo), .th_fhi(th_fhi), .th_flo(th_flo),
        .sel_a(sel_a), .sel_b(sel_b), .lim(lim), .blen(blen)
    );

    cmx_blank #(.BW(BW)) u_blank (
        .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .trans_any(|trans_act),
        .stable_mode(stable_mode), .blen(blen), .blank(blank)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign raw_w[g] = smp_data[g*DW +: DW];
        cmx_boxcar #(.DW(DW), .L(AVG_LOG2)) u_avg (
            .clk(clk), .rst_n(rst_n), .en(smp_valid),
            .fill(mt_q.refill && !blank),
            .s(raw_w[g]), .avg_o(avg_w[g])
        );
    end

    always_comb begin
        lvl_e lv;
        int   da, db, dd;
        mt_d = mt_q;
        lv   = LVL_IN;
        da   = 0;
        db   = 0;
        dd   = 0;
        if (blank) begin
            mt_d.refill = 1'b1;
            mt_d.shi    = '0;
            mt_d.slo    = '0;
            mt_d.ftr    = '0;
            mt_d.dfl    = '0;
        end else if (smp_valid) begin
            mt_d.refill = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                lv = classify(int'(avg_w[c]), int'($signed(th_shi[c])),
                              int'($signed(th_slo[c])));
                mt_d.shi[c] = (lv == LVL_HI);
                mt_d.slo[c] = (lv == LVL_LO);
                mt_d.ftr[c] = (int'(raw_w[c]) > int'($signed(th_fhi[c]))) ||
                              (int'(raw_w[c]) < int'($signed(th_flo[c])));
            end
            for (int p = 0; p < NPAIR; p++) begin
                da = int'(avg_w[sel_a[p]]);
                db = int'(avg_w[sel_b[p]]);
                dd = (da > db) ? (da - db) : (db - da);
                mt_d.dfl[p] = dd > int'(lim[p]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mt_q        <= '0;
            mt_q.refill <= 1'b1;
        end else begin
            mt_q <= mt_d;
        end
    end

    assign slow_hi   = mt_q.shi;
    assign slow_lo   = mt_q.slo;
    assign fast_trip = mt_q.ftr;
    assign diff_flag = mt_q.dfl;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && (trans_act == '0) && !blank)
        |=> $stable({slow_hi, slow_lo, fast_trip, diff_flag}));

    p_blank_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_act != '0) |=> ({slow_hi, slow_lo, fast_trip, diff_flag} == '0));

    p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ((slow_hi & slow_lo) == '0));

endmodule

// File: tb/tb_bus_fault_cmp_matrix.sv
`timescale 1ns/1ps
module tb_bus_fault_cmp_matrix;
    localparam int NCH = 8, NPAIR = 4, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smp_valid = 1'b0, stable_mode = 1'b0, cfg_we = 1'b0;
    logic [NCH*DW-1:0] smp_data = '0;
    logic [2:0]  trans_act = '0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [NCH-1:0] slow_hi, slow_lo, fast_trip;
    logic [NPAIR-1:0] diff_flag;

    always #2.5 clk = ~clk;

    bus_fault_cmp_matrix dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trans_act(trans_act), .stable_mode(stable_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .slow_hi(slow_hi),
        .slow_lo(slow_lo), .fast_trip(fast_trip), .diff_flag(diff_flag)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    int hist [NCH][16];
    int samp [NCH];
    int shi_m [NCH], slo_m [NCH], fhi_m [NCH], flo_m [NCH];
    int pa_m [NPAIR], pb_m [NPAIR], lim_m [NPAIR];
    int blen_m = 0, mcnt = 0;
    bit refill_m = 1;
    logic [NCH-1:0] e_shi = '0, e_slo = '0, e_ftr = '0;
    logic [NPAIR-1:0] e_dfl = '0;

    task automatic check(input string name, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", name, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R1 R2 slow_hi"}, 32'(slow_hi), 32'(e_shi));
        check({tag, " R1 R2 slow_lo"}, 32'(slow_lo), 32'(e_slo));
        check({tag, " R3 fast_trip"}, 32'(fast_trip), 32'(e_ftr));
        check({tag, " R4 diff_flag"}, 32'(diff_flag), 32'(e_dfl));
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_slow(input int c, input int hi, input int lo);
        wr(c, hi); wr(8 + c, lo); shi_m[c] = hi; slo_m[c] = lo;
    endtask

    task automatic set_fast(input int c, input int hi, input int lo);
        wr(16 + c, hi); wr(24 + c, lo); fhi_m[c] = hi; flo_m[c] = lo;
    endtask

    task automatic set_pair(input int p, input int a, input int b, input int l);
        wr(32 + p, a); wr(36 + p, b); wr(40 + p, l);
        pa_m[p] = a; pb_m[p] = b; lim_m[p] = l;
    endtask

    task automatic set_blen(input int n);
        wr(44, n); blen_m = n;
    endtask

    task automatic model_strobe();
        int avg [NCH];
        for (int c = 0; c < NCH; c++) begin
            if (mcnt == 0 && refill_m) begin
                for (int k = 0; k < 16; k++) hist[c][k] = samp[c];
            end else begin
                for (int k = 15; k > 0; k--) hist[c][k] = hist[c][k-1];
                hist[c][0] = samp[c];
            end
        end
        if (mcnt != 0) begin
            mcnt--; refill_m = 1;
            e_shi = '0; e_slo = '0; e_ftr = '0; e_dfl = '0;
        end else begin
            refill_m = 0;
            for (int c = 0; c < NCH; c++) begin
                int s = 0;
                for (int k = 0; k < 16; k++) s += hist[c][k];
                avg[c] = s >>> 4;
                e_shi[c] = avg[c] > shi_m[c];
                e_slo[c] = !e_shi[c] && (avg[c] < slo_m[c]);
                e_ftr[c] = (samp[c] > fhi_m[c]) || (samp[c] < flo_m[c]);
            end
            for (int p = 0; p < NPAIR; p++) begin
                int d = avg[pa_m[p]] - avg[pb_m[p]];
                if (d < 0) d = -d;
                e_dfl[p] = d > lim_m[p];
            end
        end
    endtask

    task automatic strobe(input string tag);
        @(negedge clk);
        smp_valid = 1'b1;
        for (int c = 0; c < NCH; c++) smp_data[c*DW +: DW] = 16'(samp[c]);
        model_strobe();
        @(negedge clk);
        smp_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic phase_pulse(input logic [2:0] bits);
        @(negedge clk); trans_act = bits;
        @(negedge clk); trans_act = '0;
        mcnt = blen_m; refill_m = 1;
        e_shi = '0; e_slo = '0; e_ftr = '0; e_dfl = '0;
        check("R6 flags cleared by transient",
              32'({slow_hi, slow_lo, fast_trip, diff_flag}), 32'h0);
    endtask

    task automatic stable_pulse();
        @(negedge clk); stable_mode = 1'b1;
        @(negedge clk); stable_mode = 1'b0;
        mcnt = 0;
    endtask

    task automatic fill_const(input int v);
        for (int c = 0; c < NCH; c++) samp[c] = v;
    endtask

    task automatic sweep(input int first, input int n, input string tag);
        for (int s = first; s < first + n; s++) begin
            for (int c = 0; c < NCH; c++) samp[c] = ((s * 37 + c * 53 + 11) % 401) - 200;
            if (s % 5 == 0) samp[s % NCH] = (s % 10 == 0) ? 1500 : -1500;
            strobe(tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            shi_m[c] = 32767; slo_m[c] = -32768; fhi_m[c] = 32767; flo_m[c] = -32768;
        end
        for (int p = 0; p < NPAIR; p++) begin pa_m[p] = 0; pb_m[p] = 0; lim_m[p] = 65535; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset flags", 32'({slow_hi, slow_lo, fast_trip, diff_flag}), 32'h0);

        // R11 default windows: extremes never flag
        for (int c = 0; c < NCH; c++) samp[c] = (c % 2) ? 32767 : -32768;
        strobe("R11 defaults R9 first fill");
        strobe("R11 defaults");

        for (int c = 0; c < NCH; c++) begin set_slow(c, 100, -100); set_fast(c, 1000, -1000); end
        set_pair(0, 7, 0, 50); set_pair(1, 3, 2, 20); set_pair(2, 5, 5, 0); set_pair(3, 1, 6, 5);
        set_blen(3);
        sweep(0, 40, "sweep");

        // R5: no strobe, data changes, flags hold
        @(negedge clk); smp_data = {NCH{16'h7abc}};
        repeat (3) @(negedge clk);
        check_all("R5 hold without strobe");

        // R10: change thresholds mid-run, history kept
        for (int c = 0; c < NCH; c++) set_slow(c, 20, -20);
        set_pair(0, 2, 4, 10);
        sweep(40, 20, "R10 runtime thresholds");

        // R6 R7 R9: blank for 3 strobes, then refill
        phase_pulse(3'b001);
        sweep(60, 5, "R7 extension R9 refill");
        // R7 retrigger mid-count
        phase_pulse(3'b010);
        sweep(65, 1, "R7 first blanked");
        phase_pulse(3'b100);
        sweep(66, 4, "R7 restart");
        // R8 stable mode ends blanking
        phase_pulse(3'b011);
        stable_pulse();
        sweep(70, 2, "R8 stable cut R9 refill");
        // zero-length extension
        set_blen(0);
        phase_pulse(3'b001);
        for (int c = 0; c < NCH; c++) begin set_slow(c, 100, -100); set_fast(c, 1000, -1000); end
        set_pair(0, 0, 1, 0);

        // Boundaries: exactly on threshold, then one past; negative floor
        fill_const(100); strobe("R1 on upper bound R9 refill");
        fill_const(101); strobe("R2 floor positive");
        phase_pulse(3'b001);
        fill_const(-100); strobe("R1 on lower bound");
        fill_const(-101); strobe("R2 floor negative");
        phase_pulse(3'b001);
        fill_const(1000); strobe("R3 fast on bound");
        fill_const(1001); strobe("R3 fast past bound");
        fill_const(-1001); strobe("R3 fast below");
        phase_pulse(3'b001);
        fill_const(0); samp[0] = 21; samp[1] = 0; strobe("R4 diff refill");
        set_pair(0, 0, 1, 21); strobe("R4 diff equal limit");
        set_pair(0, 0, 1, 20); strobe("R4 diff over limit R10");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule